// File: doc/BRIEF.md
# Power-on Boot Sequencer

This block runs the chip's start-up after a fundamental reset. While the active-low reset input is low, every register in the block is cleared and the core is held off. On the first clock edge that sees the reset input high, the block captures the board strap pins in a single step. These straps are the four slave-address pins, the four EEPROM-address pins, the four operating-mode pins, the halt pin and the slow-bus pin. From them it forms the 7-bit management-bus addresses.

The captured mode decides whether the block first asks an external master-bus engine to load configuration from a serial EEPROM. The request uses a one-cycle start pulse and waits for either a done or an error pulse. After that step, a captured halt strap parks the sequencer in a halted state with the management buses enabled. It stays there until the register file signals that software has cleared the halt bit. Only then is the core enabled. The bus engines and the register file are outside the block.

Top module: `boot_seq`

## Requirements
- R1: While `fund_rst_n` is sampled low, `core_en`, `ee_start`, `mgmt_en`, `halted`, `mode_err` and `load_err` are all 0 at the following edge.
- R2: All straps are captured on the first rising edge that samples `fund_rst_n` high. Strap changes after that edge do not affect `slave_addr`, `eeprom_addr` or `mgmt_slow` until the next reset.
- R3: `slave_addr[6:0]` = {1, 1, sl_pins[3], 0, sl_pins[2:0]}. Address bits 7, 6 and 4 are constant, and bits 5, 3, 2 and 1 come from the pins.
- R4: `eeprom_addr[6:0]` = {1, 0, 1, ms_pins[3:0]}.
- R5: `mgmt_slow` equals the captured slow strap (1 selects the 100 kHz rate and 0 selects 400 kHz). It has no other source.
- R6: Mode 0 with halt low: `ee_start` never rises, and `core_en` is 1 two edges after the capture edge.
- R7: Mode 1: `ee_start` is high for exactly the one cycle after the capture edge. `core_en` stays 0 until `ee_done` is sampled high in the wait state. It rises two edges after that sampling edge when halt is low.
- R8: Sampling `ee_err` high during the load wait ends the load, sets the sticky `load_err`, and continues exactly as a done does.
- R9: Modes 2 to 15 behave as mode 0 with no EEPROM request. They also set the sticky `mode_err`, which only a fundamental reset clears.
- R10: With the halt strap captured high, `halted` rises two edges after the decode or load step ends, and `core_en` stays 0. `core_en` rises one edge after `sw_halt_clr` is sampled high.
- R11: Once `core_en` is 1 it stays 1 until reset. `ee_done`, `ee_err` and `sw_halt_clr` have no effect outside the state that waits for them.
- R12: `mgmt_en` is 1 in every state except the reset wait, including the load and halted states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fund_rst_n | input | 1 | Fundamental reset, active low, sampled synchronously |
| sl_pins | input | 4 | Slave-address straps |
| ms_pins | input | 4 | EEPROM-address straps |
| mode_pins | input | 4 | Operating-mode straps |
| halt_pin | input | 1 | Halt-after-reset strap |
| slow_pin | input | 1 | Slow master-bus strap |
| ee_done | input | 1 | EEPROM load finished |
| ee_err | input | 1 | EEPROM load failed |
| sw_halt_clr | input | 1 | Software cleared the halt bit |
| ee_start | output | 1 | One-cycle EEPROM load request |
| slave_addr | output | 7 | Slave address, bits 7..1 |
| eeprom_addr | output | 7 | EEPROM address, bits 7..1 |
| mgmt_slow | output | 1 | Master bus runs at the slow rate |
| mgmt_en | output | 1 | Management buses enabled |
| halted | output | 1 | Sequencer parked awaiting software |
| core_en | output | 1 | Core released to normal operation |
| mode_err | output | 1 | Sticky reserved-mode flag |
| load_err | output | 1 | Sticky EEPROM load error flag |

## Verification
The captured addresses, `mgmt_slow` and `mgmt_en` are due one edge after reset is released. In mode 0, `core_en` follows a further edge later. `ee_start` is due one edge after release and lasts one cycle. `core_en` or `halted` is due two edges after the edge that samples done or error, and `core_en` one edge after a sampled halt clear. The bench drives and samples on the falling clock edge. It counts the rising edges between each stimulus and check, and checks the cycle before each output is due as well as the cycle it is due.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_WAIT_RST,
        ST_EE_REQ,
        ST_EE_WAIT,
        ST_HALT_CHK,
        ST_HALTED,
        ST_RUN
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_PLAIN,
        MODE_EEPROM,
        MODE_RSVD
    } mode_class_t;

    typedef struct packed {
        logic [3:0] sl;
        logic [3:0] ms;
        logic       halt;
        logic       slow;
    } strap_t;

    function automatic mode_class_t classify_mode(input logic [3:0] m);
        case (m)
            4'd0:    return MODE_PLAIN;
            4'd1:    return MODE_EEPROM;
            default: return MODE_RSVD;
        endcase
    endfunction

    // Index k of the result holds address bit k+1.
    function automatic logic [ADDR_W-1:0] make_slave_addr(input logic [3:0] p);
        return {1'b1, 1'b1, p[3], 1'b0, p[2:0]};
    endfunction

    function automatic logic [ADDR_W-1:0] make_eeprom_addr(input logic [3:0] p);
        return {1'b1, 1'b0, 1'b1, p};
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import boot_seq_pkg::*;
(
    input  logic              clk,
    input  logic              fund_rst_n,
    input  logic              capture,
    input  strap_t            straps_in,
    output logic              halt_l,
    output logic [ADDR_W-1:0] slave_addr,
    output logic [ADDR_W-1:0] eeprom_addr,
    output logic              slow
);
    strap_t held;

    always_ff @(posedge clk) begin
        if (!fund_rst_n)
            held <= '0;
        else if (capture)
            held <= straps_in;
    end

    assign halt_l      = held.halt;
    assign slow        = held.slow;
    assign slave_addr  = make_slave_addr(held.sl);
    assign eeprom_addr = make_eeprom_addr(held.ms);
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
    import boot_seq_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              fund_rst_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              halt_l,
    input  logic              ee_done,
    input  logic              ee_err,
    input  logic              sw_halt_clr,
    output logic              capture,
    output logic              ee_start,
    output logic              mgmt_en,
    output logic              halted,
    output logic              core_en,
    output logic              mode_err,
    output logic              load_err
);
    seq_state_t  state, nxt;
    mode_class_t mc;

    assign mc = classify_mode(4'(mode_pins));

    always_comb begin
        nxt = state;
        case (state)
            ST_WAIT_RST: nxt = (mc == MODE_EEPROM) ? ST_EE_REQ : ST_HALT_CHK;
            ST_EE_REQ:   nxt = ST_EE_WAIT;
            ST_EE_WAIT:  if (ee_done || ee_err) nxt = ST_HALT_CHK;
            ST_HALT_CHK: nxt = halt_l ? ST_HALTED : ST_RUN;
            ST_HALTED:   if (sw_halt_clr) nxt = ST_RUN;
            ST_RUN:      nxt = ST_RUN;
            default:     nxt = ST_WAIT_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!fund_rst_n) begin
            state    <= ST_WAIT_RST;
            mode_err <= 1'b0;
            load_err <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_WAIT_RST && mc == MODE_RSVD)
                mode_err <= 1'b1;
            if (state == ST_EE_WAIT && ee_err)
                load_err <= 1'b1;
        end
    end

    assign capture  = (state == ST_WAIT_RST) && fund_rst_n;
    assign ee_start = (state == ST_EE_REQ);
    assign mgmt_en  = (state != ST_WAIT_RST);
    assign halted   = (state == ST_HALTED);
    assign core_en  = (state == ST_RUN);
endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_seq_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              fund_rst_n,
    input  logic [3:0]        sl_pins,
    input  logic [3:0]        ms_pins,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              halt_pin,
    input  logic              slow_pin,
    input  logic              ee_done,
    input  logic              ee_err,
    input  logic              sw_halt_clr,
    output logic              ee_start,
    output logic [6:0]        slave_addr,
    output logic [6:0]        eeprom_addr,
    output logic              mgmt_slow,
    output logic              mgmt_en,
    output logic              halted,
    output logic              core_en,
    output logic              mode_err,
    output logic              load_err
);
    logic   capture;
    logic   halt_l;
    strap_t straps;

    assign straps = '{sl: sl_pins, ms: ms_pins, halt: halt_pin, slow: slow_pin};

    strap_capture u_cap (
        .clk         (clk),
        .fund_rst_n  (fund_rst_n),
        .capture     (capture),
        .straps_in   (straps),
        .halt_l      (halt_l),
        .slave_addr  (slave_addr),
        .eeprom_addr (eeprom_addr),
        .slow        (mgmt_slow)
    );

    boot_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk         (clk),
        .fund_rst_n  (fund_rst_n),
        .mode_pins   (mode_pins),
        .halt_l      (halt_l),
        .ee_done     (ee_done),
        .ee_err      (ee_err),
        .sw_halt_clr (sw_halt_clr),
        .capture     (capture),
        .ee_start    (ee_start),
        .mgmt_en     (mgmt_en),
        .halted      (halted),
        .core_en     (core_en),
        .mode_err    (mode_err),
        .load_err    (load_err)
    );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
    input logic       clk,
    input logic       fund_rst_n,
    input logic       ee_start,
    input logic [6:0] slave_addr,
    input logic [6:0] eeprom_addr,
    input logic       mgmt_slow,
    input logic       mgmt_en,
    input logic       halted,
    input logic       core_en,
    input logic       mode_err,
    input logic       load_err
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !fund_rst_n |=> !core_en && !ee_start && !mgmt_en && !halted && !mode_err && !load_err);

    // R2
    straps_held_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        (mgmt_en && $past(mgmt_en)) |-> ($stable(slave_addr) && $stable(eeprom_addr) && $stable(mgmt_slow)));

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        ee_start |=> !ee_start);

    // R9
    mode_err_sticky_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        mode_err |=> mode_err);

    // R8
    load_err_sticky_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        load_err |=> load_err);

    // R10
    halt_blocks_core_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        halted |-> !core_en && mgmt_en);

    // R11
    core_stays_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        core_en |=> core_en);

    // R12
    start_needs_bus_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
        ee_start |-> mgmt_en && !core_en);
endmodule

bind boot_seq boot_seq_chk u_chk (
    .clk         (clk),
    .fund_rst_n  (fund_rst_n),
    .ee_start    (ee_start),
    .slave_addr  (slave_addr),
    .eeprom_addr (eeprom_addr),
    .mgmt_slow   (mgmt_slow),
    .mgmt_en     (mgmt_en),
    .halted      (halted),
    .core_en     (core_en),
    .mode_err    (mode_err),
    .load_err    (load_err)
);

// File: tb/test_boot_seq.sv
module test_boot_seq;
    logic       clk = 1'b0;
    logic       fund_rst_n = 1'b0;
    logic [3:0] sl_pins = '0, ms_pins = '0, mode_pins = '0;
    logic       halt_pin = 1'b0, slow_pin = 1'b0;
    logic       ee_done = 1'b0, ee_err = 1'b0, sw_halt_clr = 1'b0;
    logic       ee_start, mgmt_slow, mgmt_en, halted, core_en, mode_err, load_err;
    logic [6:0] slave_addr, eeprom_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done_all = 1'b0;

    always #4 clk = ~clk;

    boot_seq i_boot_seq (
        .clk(clk), .fund_rst_n(fund_rst_n), .sl_pins(sl_pins), .ms_pins(ms_pins),
        .mode_pins(mode_pins), .halt_pin(halt_pin), .slow_pin(slow_pin),
        .ee_done(ee_done), .ee_err(ee_err), .sw_halt_clr(sw_halt_clr),
        .ee_start(ee_start), .slave_addr(slave_addr), .eeprom_addr(eeprom_addr),
        .mgmt_slow(mgmt_slow), .mgmt_en(mgmt_en), .halted(halted),
        .core_en(core_en), .mode_err(mode_err), .load_err(load_err)
    );

    function automatic logic [6:0] exp_sl(input logic [3:0] p);
        return {2'b11, p[3], 1'b0, p[2:0]};
    endfunction

    function automatic logic [6:0] exp_ms(input logic [3:0] p);
        return {3'b101, p};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Hold reset, set straps, release; returns right after release (falling edge).
    task automatic boot(input logic [3:0] sl, input logic [3:0] ms, input logic [3:0] md,
                        input logic hp, input logic sp);
        @(negedge clk);
        fund_rst_n = 1'b0;
        tick(3);
        sl_pins = sl; ms_pins = ms; mode_pins = md; halt_pin = hp; slow_pin = sp;
        fund_rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        fund_rst_n = 1'b0;
        mode_pins = 4'd1;
        tick(3);
        chk("R1", "core_en", core_en, 0);
        chk("R1", "ee_start", ee_start, 0);
        chk("R1", "mgmt_en", mgmt_en, 0);
        chk("R1", "flags", {halted, mode_err, load_err}, 0);
    endtask

    task automatic t_plain_mode;
        boot(4'b1010, 4'b0110, 4'd0, 1'b0, 1'b1);
        tick(1);
        chk("R12", "mgmt_en after capture", mgmt_en, 1);
        chk("R6", "core_en one edge early", core_en, 0);
        chk("R3", "slave_addr", slave_addr, exp_sl(4'b1010));
        chk("R4", "eeprom_addr", eeprom_addr, exp_ms(4'b0110));
        chk("R5", "mgmt_slow", mgmt_slow, 1);
        chk("R6", "no ee_start", ee_start, 0);
        tick(1);
        chk("R6", "core_en", core_en, 1);
        sl_pins = 4'b0101; ms_pins = 4'b1001; slow_pin = 1'b0; mode_pins = 4'd1;
        tick(3);
        chk("R2", "slave_addr held", slave_addr, exp_sl(4'b1010));
        chk("R2", "eeprom_addr held", eeprom_addr, exp_ms(4'b0110));
        chk("R2", "slow held", mgmt_slow, 1);
        chk("R11", "core_en held", core_en, 1);
        chk("R9", "no mode_err", mode_err, 0);
    endtask

    task automatic t_eeprom_ok;
        boot(4'b0101, 4'b1001, 4'd1, 1'b0, 1'b0);
        tick(1);
        chk("R7", "ee_start pulse", ee_start, 1);
        chk("R3", "slave_addr", slave_addr, exp_sl(4'b0101));
        chk("R4", "eeprom_addr", eeprom_addr, exp_ms(4'b1001));
        chk("R5", "mgmt_slow low", mgmt_slow, 0);
        tick(1);
        chk("R7", "ee_start drops", ee_start, 0);
        tick(5);
        chk("R7", "core waits for load", core_en, 0);
        chk("R12", "mgmt_en in load", mgmt_en, 1);
        sw_halt_clr = 1'b1;
        tick(1);
        sw_halt_clr = 1'b0;
        chk("R11", "halt clear ignored during load", core_en, 0);
        ee_done = 1'b1;
        tick(1);
        ee_done = 1'b0;
        chk("R7", "core one edge after done", core_en, 0);
        tick(1);
        chk("R7", "core_en after load", core_en, 1);
        chk("R8", "no load_err", load_err, 0);
    endtask

    task automatic t_eeprom_err_halt;
        boot(4'b1111, 4'b0000, 4'd1, 1'b1, 1'b0);
        tick(3);
        ee_err = 1'b1;
        tick(1);
        ee_err = 1'b0;
        chk("R8", "load_err set", load_err, 1);
        chk("R10", "not yet halted", halted, 0);
        tick(1);
        chk("R10", "halted", halted, 1);
        chk("R10", "core held", core_en, 0);
        chk("R12", "mgmt_en in halt", mgmt_en, 1);
        ee_done = 1'b1;
        tick(1);
        ee_done = 1'b0;
        tick(8);
        chk("R11", "done ignored in halt", {halted, core_en}, 2'b10);
        chk("R8", "load_err sticky", load_err, 1);
        sw_halt_clr = 1'b1;
        tick(1);
        sw_halt_clr = 1'b0;
        chk("R10", "core_en after clear", core_en, 1);
        chk("R10", "halted drops", halted, 0);
    endtask

    task automatic t_reserved;
        boot(4'b0011, 4'b1100, 4'd9, 1'b0, 1'b0);
        tick(1);
        chk("R9", "no ee_start", ee_start, 0);
        chk("R9", "mode_err set", mode_err, 1);
        tick(1);
        chk("R9", "core_en as plain", core_en, 1);
        ee_err = 1'b1;
        tick(1);
        ee_err = 1'b0;
        tick(2);
        chk("R11", "err ignored in run", load_err, 0);
        chk("R9", "mode_err sticky", mode_err, 1);
        @(negedge clk);
        fund_rst_n = 1'b0;
        tick(1);
        chk("R1", "mode_err cleared", mode_err, 0);
        chk("R1", "core_en cleared", core_en, 0);
    endtask

    task automatic t_halt_plain;
        boot(4'b0001, 4'b1111, 4'd0, 1'b1, 1'b1);
        tick(1);
        chk("R10", "halt check step", halted, 0);
        tick(1);
        chk("R10", "halted", halted, 1);
        tick(20);
        chk("R10", "core still held", core_en, 0);
        chk("R6", "no ee_start in halt", ee_start, 0);
        chk("R3", "slave_addr", slave_addr, exp_sl(4'b0001));
        chk("R4", "eeprom_addr", eeprom_addr, exp_ms(4'b1111));
        sw_halt_clr = 1'b1;
        tick(1);
        sw_halt_clr = 1'b0;
        chk("R10", "core_en", core_en, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_all) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_plain_mode();
        t_eeprom_ok();
        t_eeprom_err_halt();
        t_reserved();
        t_halt_plain();
        done_all = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule